// File: doc/BRIEF.md
# Peripheral Access Event Decoder

This block watches the system bus and reports when software touches one of the standard PC peripherals. Each bus cycle is qualified by either an I/O strobe or a memory strobe. On the first clock of each strobe, the address is compared against a set of fixed and programmable windows. Every enabled group that matches produces a one-clock pulse on its own hit flag. A combined event pulse goes high whenever any group flag pulses.

There are three kinds of decode:

- **Fixed I/O windows:** keyboard controller, floppy controller and display adapter I/O.
- **Grouped serial/parallel decode:** all serial and parallel ports share one enable, and a two-bit select chooses which base addresses are decoded.
- **Programmable I/O windows:** two of them, each given as a base and a mask.

For memory cycles, the two 64 KB display memory segments at A0000h and B0000h can each be enabled on their own. A power-management timer would typically use the combined event to restart its idle count.

Top module: `io_evt_decoder`

## Requirements
- R1: After reset, `hit_o` and `evt_o` are 0 until a strobe rising edge is seen.
- R2: An I/O cycle to port 0060h or 0064h pulses `hit_o[0]` (keyboard) when `en_kbd` is 1. All 16 I/O address bits are compared, so aliases such as 1060h do not hit.
- R3: An I/O cycle to ports 03F0h–03F1h or 03F3h–03F5h pulses `hit_o[1]` (floppy) when `en_fdc` is 1. Port 03F2h never raises it.
- R4: An I/O cycle to ports 03B0h–03BBh or 03C0h–03DFh pulses `hit_o[2]` (display I/O) when `en_vga_io` is 1.
- R5: When `en_ports` is 1, an I/O cycle to a selected serial or parallel port pulses `hit_o[3]`.
  - `port_sel[0]`=0 selects serial ports 03F8h–03FFh and 02F8h–02FFh.
  - `port_sel[0]`=1 selects serial ports 03E8h–03EFh and 02E8h–02EFh.
  - `port_sel[1]`=0 selects parallel port 0378h–037Fh.
  - `port_sel[1]`=1 selects parallel port 0278h–027Fh.
- R6: Programmable window k (k=0,1) pulses `hit_o[4+k]` on an I/O cycle when `en_rng[k]` is 1 and `(addr[15:0] & mask) == (base & mask)`.
- R7: A memory cycle pulses `hit_o[6]` when `addr[19:16]`=Ah and `en_vmem_a` is 1. It pulses `hit_o[7]` when `addr[19:16]`=Bh and `en_vmem_b` is 1. I/O groups (bits 5:0) respond only to `io_stb`, and memory groups (bits 7:6) respond only to `mem_stb`.
- R8: Hits are sampled at the clock edge where a strobe is first seen high. They appear for exactly one cycle after that edge. A strobe held high produces no further pulse.
- R9: `evt_o` pulses in exactly the cycles in which `hit_o` is nonzero. A disabled group never pulses, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (20) | Bus address |
| io_stb | input | 1 | I/O cycle strobe, active high |
| mem_stb | input | 1 | Memory cycle strobe, active high |
| en_kbd | input | 1 | Keyboard group enable |
| en_fdc | input | 1 | Floppy group enable |
| en_vga_io | input | 1 | Display I/O group enable |
| en_ports | input | 1 | Serial/parallel group enable |
| port_sel | input | 2 | Serial (bit 0) and parallel (bit 1) base select |
| en_rng | input | 2 | Programmable window enables |
| rng0_base | input | IO_W (16) | Window 0 base |
| rng0_mask | input | IO_W (16) | Window 0 compare mask |
| rng1_base | input | IO_W (16) | Window 1 base |
| rng1_mask | input | IO_W (16) | Window 1 compare mask |
| en_vmem_a | input | 1 | A0000h segment enable |
| en_vmem_b | input | 1 | B0000h segment enable |
| hit_o | output | 8 | Per-group hit pulses |
| evt_o | output | 1 | Combined event pulse |

## Verification
The bench sweeps every I/O port from 000h to 3FFh under each of the four port selects and compares all eight flags with a decode it computes itself. This catches:

- an off-by-one window edge, which hits one port too many or too few;
- a floppy decode that swallows 03F2h;
- a swapped serial/parallel select bit.

Aliased high I/O addresses and memory cycles at I/O-looking addresses are driven to expose a decode that compares too few bits or ignores the strobe type. Long-held strobes catch a level-sensitive design, which would repeat the pulse. Every memory segment is swept with each segment enable on its own, to catch crossed A/B enables.

// File: rtl/evt_dec_pkg.sv
package evt_dec_pkg;
  localparam int IO_W   = 16;
  localparam int NGRP   = 8;
  localparam int G_KBD  = 0;
  localparam int G_FDC  = 1;
  localparam int G_VGA  = 2;
  localparam int G_PORT = 3;
  localparam int G_RNG0 = 4;
  localparam int G_VMA  = 6;
  localparam int G_VMB  = 7;
  localparam int N_RNG  = 2;

  // Inclusive window test on an I/O address.
  function automatic logic in_span(input logic [IO_W-1:0] a,
                                   input logic [IO_W-1:0] lo,
                                   input logic [IO_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Eight-port block starting at an aligned base.
  function automatic logic in_oct(input logic [IO_W-1:0] a,
                                  input logic [IO_W-1:0] base);
    return a[IO_W-1:3] == base[IO_W-1:3];
  endfunction

  function automatic logic masked_eq(input logic [IO_W-1:0] a,
                                     input logic [IO_W-1:0] base,
                                     input logic [IO_W-1:0] mask);
    return (a & mask) == (base & mask);
  endfunction
endpackage

// File: rtl/io_fixed_decode.sv
module io_fixed_decode
  import evt_dec_pkg::*;
(
  input  logic [IO_W-1:0] io_addr,
  input  logic [1:0]      port_sel,
  output logic            kbd_hit,
  output logic            fdc_hit,
  output logic            vga_hit,
  output logic            port_hit
);
  logic ser_hit, par_hit;

  always_comb begin
    kbd_hit = (io_addr == 16'h0060) || (io_addr == 16'h0064);
    // 03F2h (motor control) is left out on purpose.
    fdc_hit = in_span(io_addr, 16'h03F0, 16'h03F1) ||
              in_span(io_addr, 16'h03F3, 16'h03F5);
    vga_hit = in_span(io_addr, 16'h03B0, 16'h03BB) ||
              in_span(io_addr, 16'h03C0, 16'h03DF);
    if (port_sel[0])
      ser_hit = in_oct(io_addr, 16'h03E8) || in_oct(io_addr, 16'h02E8);
    else
      ser_hit = in_oct(io_addr, 16'h03F8) || in_oct(io_addr, 16'h02F8);
    par_hit  = in_oct(io_addr, port_sel[1] ? 16'h0278 : 16'h0378);
    port_hit = ser_hit || par_hit;
  end

  always_comb begin
    a_r3_motor_port_skipped: assert (!(io_addr == 16'h03F2 && fdc_hit));
  end
endmodule

// File: rtl/io_range_match.sv
module io_range_match
  import evt_dec_pkg::*;
(
  input  logic [IO_W-1:0] io_addr,
  input  logic [IO_W-1:0] base,
  input  logic [IO_W-1:0] mask,
  output logic            hit
);
  assign hit = masked_eq(io_addr, base, mask);
endmodule

// File: rtl/mem_window_decode.sv
module mem_window_decode #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] seg,
  output logic             seg_a_hit,
  output logic             seg_b_hit
);
  localparam logic [SEG_W-1:0] SEG_A = SEG_W'(4'hA);
  localparam logic [SEG_W-1:0] SEG_B = SEG_W'(4'hB);
  assign seg_a_hit = (seg == SEG_A);
  assign seg_b_hit = (seg == SEG_B);
endmodule

// File: rtl/io_evt_decoder.sv
module io_evt_decoder
  import evt_dec_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              io_stb,
  input  logic              mem_stb,
  input  logic              en_kbd,
  input  logic              en_fdc,
  input  logic              en_vga_io,
  input  logic              en_ports,
  input  logic [1:0]        port_sel,
  input  logic [1:0]        en_rng,
  input  logic [IO_W-1:0]   rng0_base,
  input  logic [IO_W-1:0]   rng0_mask,
  input  logic [IO_W-1:0]   rng1_base,
  input  logic [IO_W-1:0]   rng1_mask,
  input  logic              en_vmem_a,
  input  logic              en_vmem_b,
  output logic [NGRP-1:0]   hit_o,
  output logic              evt_o
);
  logic [IO_W-1:0] io_addr;
  logic [SEG_W-1:0] seg;
  logic io_q, mem_q, io_edge, mem_edge;
  logic kbd_raw, fdc_raw, vga_raw, port_raw, vma_raw, vmb_raw;
  logic [N_RNG-1:0] rng_raw;
  logic [IO_W-1:0] rbase [N_RNG];
  logic [IO_W-1:0] rmask [N_RNG];
  logic [NGRP-1:0] grp_match, grp_en, grp_fire;

  assign io_addr  = bus_addr[IO_W-1:0];
  assign seg      = bus_addr[ADDR_W-1 -: SEG_W];
  assign io_edge  = io_stb && !io_q;
  assign mem_edge = mem_stb && !mem_q;
  assign rbase[0] = rng0_base;
  assign rmask[0] = rng0_mask;
  assign rbase[1] = rng1_base;
  assign rmask[1] = rng1_mask;

  io_fixed_decode u_fixed (
    .io_addr(io_addr), .port_sel(port_sel),
    .kbd_hit(kbd_raw), .fdc_hit(fdc_raw), .vga_hit(vga_raw), .port_hit(port_raw)
  );

  for (genvar k = 0; k < N_RNG; k++) begin : g_rng
    io_range_match u_rng (
      .io_addr(io_addr), .base(rbase[k]), .mask(rmask[k]), .hit(rng_raw[k])
    );
  end

  mem_window_decode #(.SEG_W(SEG_W)) u_mem (
    .seg(seg), .seg_a_hit(vma_raw), .seg_b_hit(vmb_raw)
  );

  always_comb begin
    grp_match = {vmb_raw, vma_raw, rng_raw, port_raw, vga_raw, fdc_raw, kbd_raw};
    grp_en    = {en_vmem_b, en_vmem_a, en_rng, en_ports, en_vga_io, en_fdc, en_kbd};
    grp_fire  = grp_match & grp_en &
                {{2{mem_edge}}, {(NGRP-2){io_edge}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q  <= 1'b0;
      mem_q <= 1'b0;
      hit_o <= '0;
      evt_o <= 1'b0;
    end else begin
      io_q  <= io_stb;
      mem_q <= mem_stb;
      hit_o <= grp_fire;
      evt_o <= |grp_fire;
    end
  end

  // R8: a pulse never lasts more than one cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o != '0) |=> (hit_o == '0));
  // R7: I/O groups only follow an I/O strobe edge
  a_r7_io_needs_io_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o[NGRP-3:0] != '0) |-> $past(io_stb));
  // R7: memory groups only follow a memory strobe edge
  a_r7_mem_needs_mem_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o[NGRP-1:NGRP-2] != '0) |-> $past(mem_stb));
  // R9: combined event tracks the group flags
  a_r9_evt_matches: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o == (hit_o != '0));
  // R9: a disabled keyboard group stays quiet
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_kbd) |-> !hit_o[G_KBD]);
endmodule

// File: tb/test_io_evt_decoder.sv
module test_io_evt_decoder;
  logic clk = 0, rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic io_stb = 0, mem_stb = 0;
  logic en_kbd = 0, en_fdc = 0, en_vga_io = 0, en_ports = 0;
  logic [1:0] port_sel = 0, en_rng = 0;
  logic [15:0] rng0_base = 16'h0100, rng0_mask = 16'hFFF0;
  logic [15:0] rng1_base = 16'h0380, rng1_mask = 16'hFFF8;
  logic en_vmem_a = 0, en_vmem_b = 0;
  logic [7:0] hit_o;
  logic evt_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  io_evt_decoder i_io_evt_decoder (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_io(input logic [15:0] a);
    logic [7:0] e = '0;
    logic [15:0] sb;
    e[0] = en_kbd && (a == 16'h60 || a == 16'h64);
    e[1] = en_fdc && ((a >= 16'h3F0 && a < 16'h3F6) && a != 16'h3F2);
    e[2] = en_vga_io && ((a >= 16'h3B0 && a < 16'h3BC) || (a >= 16'h3C0 && a < 16'h3E0));
    sb = port_sel[0] ? 16'h3E8 : 16'h3F8;
    e[3] = en_ports && ((a >= sb && a < sb + 8) ||
                        (a >= sb - 16'h100 && a < sb - 16'h0F8) ||
                        (a >= (port_sel[1] ? 16'h278 : 16'h378) &&
                         a < (port_sel[1] ? 16'h280 : 16'h380)));
    e[4] = en_rng[0] && (a >= 16'h100 && a <= 16'h10F);
    e[5] = en_rng[1] && (a >= 16'h380 && a <= 16'h387);
    return e;
  endfunction

  task automatic cycle_io(input logic [19:0] a, input logic [7:0] e, input string req);
    @(negedge clk); bus_addr = a; io_stb = 1;
    @(negedge clk); chk(req, hit_o, e); chk("R9", {7'd0, evt_o}, {7'd0, e != 0});
    @(negedge clk); chk("R8", hit_o, 8'h00); io_stb = 0;
  endtask

  task automatic cycle_mem(input logic [19:0] a, input logic [7:0] e, input string req);
    @(negedge clk); bus_addr = a; mem_stb = 1;
    @(negedge clk); chk(req, hit_o, e);
    @(negedge clk); chk("R8", hit_o, 8'h00); mem_stb = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {evt_o, 7'd0} | hit_o, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {evt_o, 7'd0} | hit_o, 8'h00);
    // R9: all disabled, sample sweep
    for (int a = 16'h3B0; a < 16'h400; a++) cycle_io(20'(a), 8'h00, "R9");
    cycle_io(20'h00060, 8'h00, "R9");
    en_kbd = 1; en_fdc = 1; en_vga_io = 1; en_ports = 1; en_rng = 2'b11;
    // R2..R6 full sweep under every select
    for (int s = 0; s < 4; s++) begin
      port_sel = 2'(s);
      for (int a = 0; a < 16'h400; a++) cycle_io(20'(a), exp_io(16'(a)), "R2-R6 sweep R3 R4 R5 R6");
    end
    cycle_io(20'h03F2, 8'h00, "R3");
    cycle_io(20'h01060, 8'h00, "R2");
    cycle_io(20'h04064, 8'h00, "R2");
    cycle_io(20'h0064, 8'h01, "R2");
    // R6 window disabled individually
    en_rng = 2'b10; cycle_io(20'h0105, 8'h00, "R6");
    en_rng = 2'b01; cycle_io(20'h0383, 8'h00 | exp_io(16'h383), "R6");
    // R8: long-held strobe
    @(negedge clk); bus_addr = 20'h0060; io_stb = 1;
    @(negedge clk); chk("R8", hit_o, 8'h01);
    for (int i = 0; i < 6; i++) begin @(negedge clk); chk("R8", hit_o, 8'h00); end
    io_stb = 0; @(negedge clk);
    // R7: memory cycles
    for (int m = 0; m < 4; m++) begin
      en_vmem_a = m[0]; en_vmem_b = m[1];
      for (int sg = 0; sg < 16; sg++)
        cycle_mem({4'(sg), 16'h0060},
                  {en_vmem_b && sg == 11, en_vmem_a && sg == 10, 6'd0}, "R7");
    end
    cycle_mem(20'h003F0, 8'h00, "R7");
    en_vmem_a = 1; en_vmem_b = 1;
    cycle_io(20'hA0000, 8'h00, "R7");
    cycle_io(20'hB0060, 8'h01, "R7");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule